// File: doc/BRIEF.md
# Tiled Depth-Cull Status Controller

This block holds one small status record per screen tile (a tile covers 8x8 pixels) and answers, for each (triangle, tile) pair handed to it, two questions: can the tile's depth work be skipped entirely, and if not, where does the tile's depth come from? Each record stores the farthest depth currently present in the tile and a state that says whether the tile is cleared, held in memory in packed form, or held in memory unpacked.

A query carries a tile index and the nearest depth the triangle reaches inside that tile. The test is a less-than depth test. If that nearest depth lies strictly beyond the tile's stored farthest depth, the tile is rejected. Otherwise the block names the depth source. For a cleared tile it supplies a constant, with no memory read. For other tiles it requests a fetch, in packed or unpacked form. After the pixel pipeline writes the tile back, an update reports the tile's new farthest depth and whether packing succeeded.

A fast clear resets every record without touching depth memory. It walks the table at one tile per cycle. While it runs, `clr_busy` is high and queries and updates are refused.

Top module: `zcull_tile_ctrl`

## Requirements
- R1: After reset every tile is in the cleared state with farthest depth CLEAR_DEPTH. A query with zmin <= CLEAR_DEPTH therefore returns r_cull=0 and r_src=2'b01.
- R2: A query whose q_zmin is strictly greater than the tile's stored farthest depth returns r_cull=1 and r_src=2'b00 (no source).
- R3: A query whose q_zmin equals the tile's stored farthest depth is not culled.
- R4: A non-culled query on a cleared tile returns r_src=2'b01, meaning the constant clear depth is used and no memory read is made.
- R5: A non-culled query on a tile in the packed state returns r_src=2'b10. On a tile in the unpacked state it returns r_src=2'b11.
- R6: An update accepted while idle (u_valid=1, clr_busy=0) stores u_zmax as the tile's farthest depth. It sets the state to packed when u_ok=1 and to unpacked when u_ok=0. A query in the same cycle sees the old record, and a query in the next cycle sees the new one.
- R7: clr_req sampled while idle raises clr_busy for exactly NUM_TILES cycles. After that, every tile is cleared with farthest depth CLEAR_DEPTH. A clr_req sampled while clr_busy is high is ignored and does not lengthen the walk.
- R8: While clr_busy is high, q_ready is low, and queries and updates presented in that cycle are dropped. A dropped query produces no r_valid, and a dropped update leaves no trace once the clear finishes.
- R9: r_valid is high in exactly the cycle after an accepted query (q_valid=1, q_ready=1), and low otherwise. r_cull and r_src belong to that query.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_req | input | 1 | Start a fast clear of all tiles |
| clr_busy | output | 1 | Clear walk in progress |
| q_valid | input | 1 | Query present |
| q_ready | output | 1 | Query and update can be accepted |
| q_tile | input | IDX_W | Queried tile index |
| q_zmin | input | DEPTH_W | Triangle's nearest depth in the tile |
| u_valid | input | 1 | Write-back update present |
| u_tile | input | IDX_W | Updated tile index |
| u_zmax | input | DEPTH_W | New farthest depth of the tile |
| u_ok | input | 1 | Write-back stored packed |
| r_valid | output | 1 | Query result valid |
| r_cull | output | 1 | Tile rejected |
| r_src | output | 2 | Depth source: 00 none, 01 constant, 10 packed fetch, 11 unpacked fetch |

## Verification
The bench builds the block with NUM_TILES=16 and DEPTH_W=8. With 16 tiles, random traffic revisits each tile often, so sequences like update-then-query and query-during-update hit the same record many times. A clear walk lasts only 16 cycles, which lets many clears overlap random queries and updates. The narrow 8-bit depth makes equal and one-greater comparisons against stored depths occur often, next to the directed edge cases.

// File: rtl/zcull_pkg.sv
package zcull_pkg;
  typedef enum logic [1:0] {
    TS_CLEARED = 2'd0,
    TS_PACKED  = 2'd1,
    TS_RAW     = 2'd2
  } tile_state_e;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'b00,
    SRC_CONST  = 2'b01,
    SRC_PACKED = 2'b10,
    SRC_RAW    = 2'b11
  } depth_src_e;
endpackage

// File: rtl/zcull_clear_walk.sv
module zcull_clear_walk #(
  parameter int NUM_TILES = 64,
  localparam int IDX_W = (NUM_TILES > 1) ? $clog2(NUM_TILES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_TILES - 1);

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    idx_en = 1'b0;
    if (!busy_q && start) begin
      busy_d = 1'b1;
      idx_d  = '0;
      idx_en = 1'b1;
    end else if (busy_q) begin
      idx_en = 1'b1;
      idx_d  = idx_q + 1'b1;
      if (idx_q == LAST) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  assign busy   = busy_q;
  assign wr_en  = busy_q;
  assign wr_idx = idx_q;

  // R7
  walk_ends_at_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(idx_q) == LAST);
  // R7
  walk_starts_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> idx_q == '0);
endmodule

// File: rtl/zcull_status_table.sv
module zcull_status_table
  import zcull_pkg::*;
#(
  parameter int NUM_TILES = 64,
  parameter int DEPTH_W = 16,
  parameter logic [DEPTH_W-1:0] CLEAR_DEPTH = '1,
  localparam int IDX_W = (NUM_TILES > 1) ? $clog2(NUM_TILES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   rd_idx,
  output tile_state_e        rd_state,
  output logic [DEPTH_W-1:0] rd_zmax,
  input  logic               clr_en,
  input  logic [IDX_W-1:0]   clr_idx,
  input  logic               up_en,
  input  logic [IDX_W-1:0]   up_idx,
  input  logic [DEPTH_W-1:0] up_zmax,
  input  logic               up_ok
);
  tile_state_e        st_q [NUM_TILES];
  logic [DEPTH_W-1:0] zm_q [NUM_TILES];
  tile_state_e        st_d [NUM_TILES];
  logic [DEPTH_W-1:0] zm_d [NUM_TILES];
  logic               we   [NUM_TILES];

  always_comb begin
    for (int t = 0; t < NUM_TILES; t++) begin
      st_d[t] = st_q[t];
      zm_d[t] = zm_q[t];
      we[t]   = 1'b0;
      if (clr_en && clr_idx == IDX_W'(t)) begin
        we[t]   = 1'b1;
        st_d[t] = TS_CLEARED;
        zm_d[t] = CLEAR_DEPTH;
      end else if (up_en && up_idx == IDX_W'(t)) begin
        we[t]   = 1'b1;
        st_d[t] = up_ok ? TS_PACKED : TS_RAW;
        zm_d[t] = up_zmax;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NUM_TILES; t++) begin
        st_q[t] <= TS_CLEARED;
        zm_q[t] <= CLEAR_DEPTH;
      end
    end else begin
      for (int t = 0; t < NUM_TILES; t++) begin
        if (we[t]) begin
          st_q[t] <= st_d[t];
          zm_q[t] <= zm_d[t];
        end
      end
    end
  end

  assign rd_state = st_q[rd_idx];
  assign rd_zmax  = zm_q[rd_idx];

  // R6
  update_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_en && !clr_en && rd_idx == up_idx |=> $stable(rd_idx) |->
      (rd_zmax == $past(up_zmax) && rd_state == ($past(up_ok) ? TS_PACKED : TS_RAW)));
  // R7
  clear_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en && rd_idx == clr_idx |=> $stable(rd_idx) |->
      (rd_state == TS_CLEARED && rd_zmax == CLEAR_DEPTH));
endmodule

// File: rtl/zcull_decide.sv
module zcull_decide
  import zcull_pkg::*;
#(
  parameter int DEPTH_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               q_fire,
  input  logic [DEPTH_W-1:0] q_zmin,
  input  tile_state_e        rd_state,
  input  logic [DEPTH_W-1:0] rd_zmax,
  output logic               r_valid,
  output logic               r_cull,
  output depth_src_e         r_src
);
  logic       cull_d;
  depth_src_e src_d;
  logic       val_q, cull_q;
  depth_src_e src_q;

  always_comb begin
    cull_d = q_zmin > rd_zmax;
    if (cull_d) src_d = SRC_NONE;
    else begin
      unique case (rd_state)
        TS_CLEARED: src_d = SRC_CONST;
        TS_PACKED:  src_d = SRC_PACKED;
        default:    src_d = SRC_RAW;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= 1'b0;
      cull_q <= 1'b0;
      src_q  <= SRC_NONE;
    end else begin
      val_q <= q_fire;
      if (q_fire) begin
        cull_q <= cull_d;
        src_q  <= src_d;
      end
    end
  end

  assign r_valid = val_q;
  assign r_cull  = cull_q;
  assign r_src   = src_q;

  // R4
  cleared_uses_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_fire && rd_state == TS_CLEARED && q_zmin <= rd_zmax |=> r_src == SRC_CONST);
  // R2
  culled_no_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_fire && q_zmin > rd_zmax |=> r_cull && r_src == SRC_NONE);
endmodule

// File: rtl/zcull_tile_ctrl.sv
module zcull_tile_ctrl
  import zcull_pkg::*;
#(
  parameter int NUM_TILES = 64,
  parameter int DEPTH_W = 16,
  parameter logic [DEPTH_W-1:0] CLEAR_DEPTH = '1,
  localparam int IDX_W = (NUM_TILES > 1) ? $clog2(NUM_TILES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_req,
  output logic               clr_busy,
  input  logic               q_valid,
  output logic               q_ready,
  input  logic [IDX_W-1:0]   q_tile,
  input  logic [DEPTH_W-1:0] q_zmin,
  input  logic               u_valid,
  input  logic [IDX_W-1:0]   u_tile,
  input  logic [DEPTH_W-1:0] u_zmax,
  input  logic               u_ok,
  output logic               r_valid,
  output logic               r_cull,
  output logic [1:0]         r_src
);
  logic             busy, clr_wr;
  logic [IDX_W-1:0] clr_idx;
  tile_state_e      rd_state;
  logic [DEPTH_W-1:0] rd_zmax;
  depth_src_e       src;
  logic             q_fire, u_fire;

  assign q_fire = q_valid && !busy;
  assign u_fire = u_valid && !busy;

  zcull_clear_walk #(.NUM_TILES(NUM_TILES)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(clr_req),
    .busy(busy), .wr_en(clr_wr), .wr_idx(clr_idx)
  );

  zcull_status_table #(.NUM_TILES(NUM_TILES), .DEPTH_W(DEPTH_W), .CLEAR_DEPTH(CLEAR_DEPTH)) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(q_tile), .rd_state(rd_state), .rd_zmax(rd_zmax),
    .clr_en(clr_wr), .clr_idx(clr_idx),
    .up_en(u_fire), .up_idx(u_tile), .up_zmax(u_zmax), .up_ok(u_ok)
  );

  zcull_decide #(.DEPTH_W(DEPTH_W)) u_decide (
    .clk(clk), .rst_n(rst_n), .q_fire(q_fire), .q_zmin(q_zmin),
    .rd_state(rd_state), .rd_zmax(rd_zmax),
    .r_valid(r_valid), .r_cull(r_cull), .r_src(src)
  );

  assign clr_busy = busy;
  assign q_ready  = !busy;
  assign r_src    = src;

  // R8
  busy_drops_query_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |=> !r_valid);
  // R9
  result_follows_query_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid && q_ready |=> r_valid);
  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req && !clr_busy |=> clr_busy);
endmodule

// File: tb/tb_zcull_tile_ctrl.sv
module tb_zcull_tile_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 16;
  localparam int DW = 8;
  localparam int IW = 4;
  localparam logic [DW-1:0] CLRV = 8'hFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic clr_req = 0, q_valid = 0, u_valid = 0, u_ok = 0;
  logic [IW-1:0] q_tile = '0, u_tile = '0;
  logic [DW-1:0] q_zmin = '0, u_zmax = '0;
  logic clr_busy, q_ready, r_valid, r_cull;
  logic [1:0] r_src;

  always #(CLK_PERIOD/2) clk = ~clk;

  zcull_tile_ctrl #(.NUM_TILES(NT), .DEPTH_W(DW), .CLEAR_DEPTH(CLRV)) dut (
    .clk(clk), .rst_n(rst_n), .clr_req(clr_req), .clr_busy(clr_busy),
    .q_valid(q_valid), .q_ready(q_ready), .q_tile(q_tile), .q_zmin(q_zmin),
    .u_valid(u_valid), .u_tile(u_tile), .u_zmax(u_zmax), .u_ok(u_ok),
    .r_valid(r_valid), .r_cull(r_cull), .r_src(r_src)
  );

  // model: state 0 cleared, 1 packed, 2 unpacked
  int m_st [NT];
  logic [DW-1:0] m_zm [NT];
  int bcnt = 0;
  int n_chk = 0, n_bad = 0;
  logic e_val = 0, e_cull = 0;
  logic [1:0] e_src = 0;

  function automatic logic [1:0] exp_src(int st, logic [DW-1:0] zm, logic [DW-1:0] zmin);
    if (zmin > zm) return 2'b00;
    if (st == 0) return 2'b01;
    if (st == 1) return 2'b10;
    return 2'b11;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one clock: drive, update model, check after edge (at negedge)
  task automatic cyc(logic c, logic qv, int qt, logic [DW-1:0] qz,
                     logic uv, int ut, logic [DW-1:0] uz, logic uk, string req);
    logic busy_now;
    busy_now = (bcnt > 0);
    clr_req = c; q_valid = qv; q_tile = IW'(qt); q_zmin = qz;
    u_valid = uv; u_tile = IW'(ut); u_zmax = uz; u_ok = uk;
    e_val = qv && !busy_now;
    if (e_val) begin
      e_src  = exp_src(m_st[qt], m_zm[qt], qz);
      e_cull = (qz > m_zm[qt]);
    end
    if (uv && !busy_now) begin
      m_st[ut] = uk ? 1 : 2;
      m_zm[ut] = uz;
    end
    if (c && !busy_now) begin
      for (int t = 0; t < NT; t++) begin m_st[t] = 0; m_zm[t] = CLRV; end
      bcnt = NT;
    end else if (bcnt > 0) bcnt--;
    @(posedge clk);
    @(negedge clk);
    chk({req, " busy(R7)"}, clr_busy, bcnt > 0);
    chk({req, " ready(R8)"}, q_ready, !(bcnt > 0));
    chk({req, " valid(R9)"}, r_valid, e_val);
    if (e_val) begin
      chk({req, " cull"}, r_cull, e_cull);
      chk({req, " src"}, r_src, e_src);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, "idle");
  endtask

  initial begin
    for (int t = 0; t < NT; t++) begin m_st[t] = 0; m_zm[t] = CLRV; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, every tile cleared
    chk("R1 busy", clr_busy, 0);
    chk("R1 rvalid", r_valid, 0);
    for (int t = 0; t < NT; t++) cyc(0, 1, t, 8'h40, 0, 0, 0, 0, "R1 reset query");
    cyc(0, 1, 3, CLRV, 0, 0, 0, 0, "R1 R3 zmin at clear depth");
    // R6 R5: packed and unpacked updates
    cyc(0, 0, 0, 0, 1, 2, 8'h50, 1, "R6 update packed");
    cyc(0, 1, 2, 8'h50, 1, 5, 8'h30, 0, "R3 R5 equal not culled packed");
    cyc(0, 1, 2, 8'h51, 0, 0, 0, 0, "R2 one beyond culled");
    cyc(0, 1, 5, 8'h10, 0, 0, 0, 0, "R5 unpacked fetch");
    // R6 same-cycle query sees old record
    cyc(0, 1, 7, 8'h80, 1, 7, 8'h20, 1, "R6 same-cycle old");
    cyc(0, 1, 7, 8'h80, 0, 0, 0, 0, "R6 next-cycle new R2");
    cyc(0, 1, 9, 8'h00, 0, 0, 0, 0, "R4 cleared zero");
    // R7 R8: clear, with queries/updates/clears during busy
    cyc(1, 1, 2, 8'h60, 0, 0, 0, 0, "R7 clear start");
    cyc(0, 1, 2, 8'h60, 1, 4, 8'h01, 1, "R8 drop during busy");
    cyc(1, 0, 0, 0, 0, 0, 0, 0, "R7 clr while busy ignored");
    idle(NT);
    for (int t = 0; t < NT; t++) cyc(0, 1, t, CLRV, 0, 0, 0, 0, "R7 R8 after clear");
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic c, qv, uv, uk;
      int qt, ut;
      logic [DW-1:0] qz, uz;
      c  = ($urandom_range(0, 99) < 2);
      qv = ($urandom_range(0, 99) < 70);
      uv = ($urandom_range(0, 99) < 40);
      uk = $urandom_range(0, 1) == 1;
      qt = $urandom_range(0, NT-1);
      ut = ($urandom_range(0, 3) == 0) ? qt : $urandom_range(0, NT-1);
      uz = 8'($urandom_range(0, 255));
      qz = ($urandom_range(0, 3) == 0) ? m_zm[qt] + 8'($urandom_range(0, 1))
                                       : 8'($urandom_range(0, 255));
      cyc(c, qv, qt, qz, uv, ut, uz, uk, "random R2 R5 R6 R9");
    end
    idle(NT + 2);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule